// File: doc/BRIEF.md
# NAND Prefetch and Postwrite Buffer

This block sits between a host and the data phase of a NAND flash port. It moves bytes in one of two directions. In read mode it fetches ahead from the device into a 64-byte circular buffer, and the host then pulls bytes out one at a time. In write mode the host pushes bytes that go straight to the device. When the device is 16 bits wide, the block pairs two host bytes into one halfword cycle.

A programmable threshold decides when the host is told to come back for more. That notice goes out as a DMA request line and as a sticky FIFO-event status bit. A second sticky status bit marks the end of the programmed transfer. The interrupt output is the OR of the status bits that are enabled.

The register port is a simple synchronous write strobe with a combinational read-back. It uses these word addresses:
- 0: configuration
- 1: transfer length
- 2: start/stop
- 3: status
- 4: interrupt status
- 5: interrupt enable

A NAND data cycle uses a request/acknowledge pair and completes on any clock where both are high.

Top module: `nand_prefetch_engine`

## Requirements
- R1: After reset the configuration reads 0x00004000 (threshold 64, read mode), and status, start/stop and interrupt status read 0. The irq and dma_req outputs are low.
- R2: Configuration keeps only mask 0x7F0D. The meaning of its bits is: bit 0 = write mode, bit 2 = DMA enable, bit 3 = 16-bit device, bits 14:8 = threshold. Transfer length keeps 14 bits and interrupt enable keeps mask 0xF03. Writes to configuration or transfer length are ignored while the engine runs, and writes to status are ignored.
- R3: Writing 1 to start/stop in read mode loads the remaining count from the transfer length and empties the buffer. The block then issues one NAND read cycle per acknowledged clock until the buffer holds 64 bytes or the count is zero. Host reads return the fetched bytes in fetch order.
- R4: In read mode, when a host read lowers the fill level to 64 minus the threshold, fetching resumes until the buffer is full again or the count is exhausted.
- R5: A host read of an empty buffer returns the last byte read again and leaves the fill level at 0.
- R6: dma_req is low whenever DMA enable is 0. It falls on the host read that reaches the refill point, and it rises again when a fill ends with data in the buffer.
- R7: Interrupt status bit 0 is set on every clock where fill level >= threshold. Writing 1 to an interrupt status bit clears it.
- R8: Interrupt status bit 1 is set when the remaining count reaches zero through transfer. The engine then stops, and start/stop reads 0.
- R9: With a 16-bit device in read mode, each NAND read cycle delivers two bytes (bits 7:0 first), and the count drops by 2.
- R10: In write mode with an 8-bit device, each accepted host byte becomes one NAND write cycle carrying that byte in bits 7:0, and the count drops by 1.
- R11: In write mode with a 16-bit device, the first byte of a pair is held and the status fill field reads 63. The second byte produces one halfword write {second, first}, the count drops by 1, and the fill field returns to 64.
- R12: Host reads in write mode return 0. Host writes in read mode, or while the remaining count is 0, issue no NAND cycle.
- R13: Writing 0 to start/stop while running forces the remaining count to 0 without setting interrupt status bit 1. No further NAND reads are issued, and the bytes already buffered can still be read out.
- R14: Status reads {0, fill[6:0], 7'b0, fill>=threshold, 2'b0, count[13:0]}. irq is high exactly when an enabled interrupt status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| host_rd | input | 1 | Pop one byte from the buffer |
| host_rdata | output | 8 | Byte returned by the last host read |
| host_wr | input | 1 | Push one byte towards the device |
| host_wdata | input | 8 | Host write byte |
| nand_req | output | 1 | NAND data cycle request |
| nand_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| nand_wide | output | 1 | Cycle is a halfword |
| nand_wdata | output | 16 | Write cycle data |
| nand_ack | input | 1 | Cycle completes this clock |
| nand_rdata | input | 16 | Read cycle data |
| dma_req | output | 1 | DMA service request |
| irq | output | 1 | Interrupt |

## Verification
The fill level, read pointer and remaining count are the state that matters. A slip in any of them becomes visible at the ports within one host read: a byte comes back out of order, or the packed status word disagrees on the very next register read. A wrong refill point shows up as dma_req failing to drop on the exact read that crosses the threshold. A stuck fetch enable shows up as extra NAND cycles after a stop or after the terminal count. Postwrite pairing errors appear on the first halfword cycle, as swapped or merged bytes.

// File: rtl/nand_prefetch_engine.sv
module nand_prefetch_engine #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        host_rd,
  output logic [7:0]  host_rdata,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  output logic        nand_req,
  output logic        nand_we,
  output logic        nand_wide,
  output logic [15:0] nand_wdata,
  input  logic        nand_ack,
  input  logic [15:0] nand_rdata,
  output logic        dma_req,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int FW = PW + 1;

  logic [14:0]      cfg_q;
  logic [CNT_W-1:0] xfer_q, cnt_q;
  logic             running_q, filling_q, dma_q, pend_q, pend_wide_q;
  logic [FW-1:0]    fill_q;
  logic [PW-1:0]    rptr_q, wptr_q;
  logic [7:0]       mem [DEPTH];
  logic [7:0]       rdata_q, hold_q;
  logic [15:0]      pend_data_q;
  logic [1:0]       irq_st_q;
  logic [11:0]      irq_en_q;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[31:15];

  wire       wr_mode = cfg_q[0];
  wire       dma_en  = cfg_q[2];
  wire       wide    = cfg_q[3];
  wire [7:0] thr8    = {1'b0, cfg_q[14:8]};
  wire [7:0] fill8   = 8'(fill_q);

  wire       room     = wide ? (fill8 <= 8'(DEPTH - 2)) : (fill8 <= 8'(DEPTH - 1));
  wire       fetch    = !wr_mode && !pend_q && filling_q && (cnt_q != '0) && room;
  wire       got      = fetch && nand_ack;
  wire [1:0] nbytes   = (wide && cnt_q >= CNT_W'(2)) ? 2'd2 : 2'd1;
  wire       pop      = host_rd && !wr_mode && (fill_q != '0);
  wire [FW-1:0] fill_rd_nxt = fill_q + (got ? FW'(nbytes) : FW'(0)) - (pop ? FW'(1) : FW'(0));
  wire       refill_hit = pop && (fill8 - 8'd1 == 8'(DEPTH) - thr8);
  wire       done     = filling_q && !fetch;
  wire       tc_rd    = done && running_q && (cnt_q == '0);
  wire       hw_ok    = host_wr && wr_mode && (cnt_q != '0) && (!pend_q || nand_ack);
  wire       hold_first = wide && (fill_q == FW'(DEPTH));
  wire       tc_wr    = hw_ok && !hold_first && (cnt_q == CNT_W'(1));
  wire       ctl_w    = reg_we && reg_addr == 3'd2 && (reg_wdata[0] != running_q);
  wire [1:0] st_clr   = (reg_we && reg_addr == 3'd4) ? reg_wdata[1:0] : 2'b00;

  assign nand_req   = fetch || pend_q;
  assign nand_we    = pend_q;
  assign nand_wide  = pend_q ? pend_wide_q : wide;
  assign nand_wdata = pend_data_q;
  assign host_rdata = rdata_q;
  assign dma_req    = dma_q && dma_en;
  assign irq        = |({10'b0, irq_st_q} & irq_en_q);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {17'b0, cfg_q};
      3'd1:    reg_rdata = 32'(xfer_q);
      3'd2:    reg_rdata = {31'b0, running_q};
      3'd3:    reg_rdata = {1'b0, 7'(fill_q), 7'b0, fill8 >= thr8, 2'b0, 14'(cnt_q)};
      3'd4:    reg_rdata = {30'b0, irq_st_q};
      3'd5:    reg_rdata = {20'b0, irq_en_q};
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (got) begin
      mem[wptr_q] <= nand_rdata[7:0];
      if (nbytes == 2'd2) mem[PW'(wptr_q + PW'(1))] <= nand_rdata[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= 15'h4000;  xfer_q <= '0;     cnt_q <= '0;
      running_q <= 1'b0;  filling_q <= 1'b0; dma_q <= 1'b0;
      pend_q <= 1'b0;     pend_wide_q <= 1'b0; pend_data_q <= '0;
      fill_q <= '0;       rptr_q <= '0;     wptr_q <= '0;
      rdata_q <= '0;      hold_q <= '0;     irq_st_q <= '0; irq_en_q <= '0;
    end else begin
      if (reg_we && reg_addr == 3'd0 && !running_q) cfg_q <= reg_wdata[14:0] & 15'h7F0D;
      if (reg_we && reg_addr == 3'd1 && !running_q) xfer_q <= reg_wdata[CNT_W-1:0];
      if (reg_we && reg_addr == 3'd5) irq_en_q <= reg_wdata[11:0] & 12'hF03;
      irq_st_q <= (irq_st_q & ~st_clr) | {tc_rd || tc_wr, fill8 >= thr8};

      if (got) begin
        wptr_q <= wptr_q + PW'(nbytes);
        cnt_q  <= cnt_q - CNT_W'(nbytes);
      end
      if (pop) begin
        rptr_q  <= rptr_q + PW'(1);
        rdata_q <= mem[rptr_q];
      end
      if (host_rd && wr_mode) rdata_q <= 8'h00;
      if (!wr_mode) fill_q <= fill_rd_nxt;
      if (refill_hit) begin
        filling_q <= 1'b1;
        dma_q     <= 1'b0;
      end else if (done) begin
        filling_q <= 1'b0;
        if (fill_rd_nxt != '0) dma_q <= 1'b1;
      end

      if (pend_q && nand_ack) pend_q <= 1'b0;
      if (hw_ok) begin
        if (hold_first) begin
          hold_q <= host_wdata;
          fill_q <= FW'(DEPTH - 1);
        end else begin
          pend_q      <= 1'b1;
          pend_wide_q <= wide;
          pend_data_q <= wide ? {host_wdata, hold_q} : {8'h00, host_wdata};
          cnt_q       <= cnt_q - CNT_W'(1);
          if (wide) fill_q <= FW'(DEPTH);
        end
      end

      if (tc_rd || tc_wr) running_q <= 1'b0;
      if (ctl_w) begin
        running_q <= reg_wdata[0];
        if (reg_wdata[0]) begin
          cnt_q <= xfer_q;
          if (wr_mode) fill_q <= FW'(DEPTH);
          else begin
            fill_q    <= '0;
            rptr_q    <= '0;
            wptr_q    <= '0;
            filling_q <= 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end
endmodule

module nand_prefetch_engine_chk #(
  parameter int DEPTH = 64,
  parameter int FW = 7,
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_rd,
  input logic [7:0]       host_rdata,
  input logic             dma_req,
  input logic [FW-1:0]    fill,
  input logic [CNT_W-1:0] cnt,
  input logic [14:0]      cfg,
  input logic             running,
  input logic [1:0]       irq_st
);
  wire [7:0] f8 = 8'(fill);
  wire [7:0] refill_at = 8'(DEPTH) - {1'b0, cfg[14:8]} + 8'd1;

  p_fill_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    f8 <= 8'(DEPTH));
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(cfg));
  p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !cfg[0] && fill == '0) |=> $stable(host_rdata));
  p_dma_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !cfg[0] && fill != '0 && f8 == refill_at) |=> !dma_req);
  p_tc_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_st[1]) |-> !running);
  p_stop_count_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> cnt == '0);
  p_write_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0] && running) |-> f8 >= 8'(DEPTH - 1));
endmodule

bind nand_prefetch_engine nand_prefetch_engine_chk #(
  .DEPTH(DEPTH), .FW(FW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_rdata(host_rdata),
  .dma_req(dma_req), .fill(fill_q), .cnt(cnt_q), .cfg(cfg_q),
  .running(running_q), .irq_st(irq_st_q)
);

// File: tb/nand_prefetch_engine_bench.sv
`timescale 1ns/100ps
module nand_prefetch_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0; logic [2:0] reg_addr = '0; logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic host_rd = 1'b0, host_wr = 1'b0; logic [7:0] host_wdata = '0; logic [7:0] host_rdata;
  logic nand_req, nand_we, nand_wide; logic [15:0] nand_wdata, nand_rdata;
  logic nand_ack = 1'b1;
  logic dma_req, irq;

  int nchk = 0, nfail = 0;
  int rseq = 0, nfetch = 0, wn = 0;
  logic [16:0] wlog [32];
  bit finished = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 37 + 5);
  endfunction

  assign nand_rdata = {pat(rseq + 1), pat(rseq)};

  always @(posedge clk) begin
    if (nand_req && nand_ack && !nand_we) begin
      rseq   <= rseq + (nand_wide ? 2 : 1);
      nfetch <= nfetch + 1;
    end
    if (nand_req && nand_ack && nand_we) begin
      wlog[wn % 32] <= {nand_wide, nand_wdata};
      wn <= wn + 1;
    end
  end

  nand_prefetch_engine u_nand_prefetch_engine (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .host_rd, .host_rdata, .host_wr, .host_wdata,
    .nand_req, .nand_we, .nand_wide, .nand_wdata, .nand_ack, .nand_rdata,
    .dma_req, .irq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic host_read(output logic [7:0] d);
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  localparam int NT = 7;
  localparam logic [2:0]  TA [NT] = '{3'd0, 3'd0, 3'd1, 3'd1, 3'd5, 3'd5, 3'd3};
  localparam logic [31:0] TW [NT] = '{32'hFFFF_FFFF, 32'h0000_4000, 32'hFFFF_FFFF, 32'h0,
                                      32'hFFFF_FFFF, 32'h0000_0003, 32'hFFFF_FFFF};
  localparam logic [31:0] TE [NT] = '{32'h0000_7F0D, 32'h0000_4000, 32'h0000_3FFF, 32'h0,
                                      32'h0000_0F03, 32'h0000_0003, 32'h0};

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  b;
    int base, f0, w0, bad;

    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    reg_read(3'd0, r); chk("R1 config", r, 32'h4000);
    reg_read(3'd3, r); chk("R1 status", r, 32'h0);
    reg_read(3'd2, r); chk("R1 start", r, 32'h0);
    reg_read(3'd4, r); chk("R1 irq status", r, 32'h0);
    chk("R1 irq/dma pins", {30'b0, irq, dma_req}, 32'h0);

    // R2 register masks, R14 status not writable: table walk
    for (int i = 0; i < NT; i++) begin
      reg_write(TA[i], TW[i]);
      reg_read(TA[i], r);
      chk("R2 register mask", r, TE[i]);
    end

    // Narrow read with threshold 16 and DMA enabled
    reg_write(3'd0, 32'h0000_1004);
    reg_write(3'd1, 32'd100);
    base = rseq; f0 = nfetch;
    reg_write(3'd2, 32'h1);
    wait_cyc(80);
    reg_read(3'd3, r); chk("R3 R14 status after first fill", r, 32'h4001_0024);
    chk("R6 dma up after fill", {31'b0, dma_req}, 32'h1);
    chk("R14 irq from fifo event", {31'b0, irq}, 32'h1);
    bad = 0;
    for (int k = 0; k < 15; k++) begin
      host_read(b);
      if (b !== pat(base + k)) bad++;
    end
    chk("R6 dma held before refill point", {31'b0, dma_req}, 32'h1);
    host_read(b);
    if (b !== pat(base + 15)) bad++;
    chk("R6 dma drops at refill point", {31'b0, dma_req}, 32'h0);
    wait_cyc(30);
    reg_read(3'd3, r); chk("R4 refill to full", r, 32'h4001_0014);
    chk("R6 dma back after refill", {31'b0, dma_req}, 32'h1);
    for (int k = 16; k < 100; k++) begin
      host_read(b);
      if (b !== pat(base + k)) bad++;
    end
    chk("R3 R4 byte order over 100 bytes", 32'(bad), 32'h0);
    chk("R3 fetch cycles", 32'(nfetch - f0), 32'd100);
    host_read(b);
    chk("R5 empty read repeats", 32'(b), 32'(pat(base + 99)));
    reg_read(3'd3, r); chk("R5 fill stays zero", r, 32'h0);
    reg_read(3'd2, r); chk("R8 engine stopped", r, 32'h0);
    reg_read(3'd4, r); chk("R7 R8 status bits", r, 32'h3);
    reg_write(3'd4, 32'h1);
    reg_read(3'd4, r); chk("R7 write-one clears event", r, 32'h2);
    chk("R14 irq from terminal count", {31'b0, irq}, 32'h1);
    reg_write(3'd4, 32'h2);
    reg_read(3'd4, r); chk("R8 write-one clears tc", r, 32'h0);
    chk("R14 irq low", {31'b0, irq}, 32'h0);

    // Wide read, DMA disabled
    reg_write(3'd0, 32'h0000_4008);
    reg_write(3'd1, 32'd8);
    base = rseq; f0 = nfetch;
    reg_write(3'd2, 32'h1);
    wait_cyc(20);
    chk("R9 halfword cycles", 32'(nfetch - f0), 32'd4);
    reg_read(3'd3, r); chk("R9 status", r, 32'h0800_0000);
    chk("R6 dma gated off", {31'b0, dma_req}, 32'h0);
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      host_read(b);
      if (b !== pat(base + k)) bad++;
    end
    chk("R9 low byte first order", 32'(bad), 32'h0);
    reg_write(3'd4, 32'h3);

    // Stop while running
    reg_write(3'd0, 32'h0000_4000);
    reg_write(3'd1, 32'd200);
    base = rseq;
    reg_write(3'd2, 32'h1);
    wait_cyc(80);
    reg_read(3'd3, r); chk("R3 fill stops at full", r, 32'h4001_0088);
    reg_write(3'd0, 32'h0000_1004);
    reg_read(3'd0, r); chk("R2 config frozen while running", r, 32'h4000);
    reg_write(3'd1, 32'd5);
    reg_read(3'd1, r); chk("R2 length frozen while running", r, 32'd200);
    reg_write(3'd2, 32'h0);
    reg_read(3'd3, r); chk("R13 stop zeroes count", r, 32'h4001_0000);
    f0 = nfetch; bad = 0;
    for (int k = 0; k < 64; k++) begin
      host_read(b);
      if (b !== pat(base + k)) bad++;
    end
    chk("R13 drain after stop", 32'(bad), 32'h0);
    chk("R13 no fetch after stop", 32'(nfetch - f0), 32'h0);
    reg_read(3'd4, r); chk("R13 no terminal count on stop", r & 32'h2, 32'h0);
    reg_write(3'd4, 32'h3);

    // Narrow postwrite
    reg_write(3'd0, 32'h0000_4001);
    reg_write(3'd1, 32'd3);
    w0 = wn;
    reg_write(3'd2, 32'h1);
    host_write(8'hA5); host_write(8'h3C); host_write(8'h7E); host_write(8'h99);
    wait_cyc(4);
    chk("R10 write cycles", 32'(wn - w0), 32'd3);
    chk("R10 byte 0", 32'(wlog[(w0) % 32]), 32'h0000_00A5);
    chk("R10 byte 1", 32'(wlog[(w0 + 1) % 32]), 32'h0000_003C);
    chk("R10 byte 2", 32'(wlog[(w0 + 2) % 32]), 32'h0000_007E);
    reg_read(3'd2, r); chk("R8 write mode stops", r, 32'h0);
    reg_read(3'd4, r); chk("R8 write mode tc", r & 32'h2, 32'h2);
    host_read(b);
    chk("R12 read in write mode", 32'(b), 32'h0);
    reg_write(3'd4, 32'h3);

    // Wide postwrite
    reg_write(3'd0, 32'h0000_4009);
    reg_write(3'd1, 32'd2);
    w0 = wn;
    reg_write(3'd2, 32'h1);
    reg_read(3'd3, r); chk("R11 fill 64 at start", r, 32'h4001_0002);
    host_write(8'h11);
    reg_read(3'd3, r); chk("R11 first byte held", r, 32'h3F00_0002);
    chk("R11 no cycle on first byte", 32'(wn - w0), 32'h0);
    host_write(8'h22);
    wait_cyc(3);
    reg_read(3'd3, r); chk("R11 pair issued", r, 32'h4001_0001);
    host_write(8'h33); host_write(8'h44);
    wait_cyc(3);
    chk("R11 halfword cycles", 32'(wn - w0), 32'd2);
    chk("R11 halfword 0", 32'(wlog[(w0) % 32]), 32'h0001_2211);
    chk("R11 halfword 1", 32'(wlog[(w0 + 1) % 32]), 32'h0001_4433);
    w0 = wn;
    host_write(8'h66);
    wait_cyc(3);
    chk("R12 write with zero count ignored", 32'(wn - w0), 32'h0);

    // Host write in read mode
    reg_write(3'd0, 32'h0000_4000);
    reg_write(3'd1, 32'd4);
    w0 = wn;
    host_write(8'h55);
    wait_cyc(3);
    chk("R12 write in read mode ignored", 32'(wn - w0), 32'h0);

    summary();
  end
endmodule